// File: doc/BRIEF.md
# Slowdown-Bound Bandwidth Allocation Controller

This block is a feedback controller that sets how much memory bandwidth one latency-sensitive application receives. The share is an 8-bit fraction of 256 and stands for the fraction of scheduling epochs in which that application has top priority at the memory controller. The complement, 256 minus the share, goes out on a separate port so that the other applications can split it.

Once per measurement interval an upstream estimator presents the application's slowdown. The slowdown, the target bound and the tolerance are all unsigned fixed-point numbers with 8 fractional bits. The controller counts intervals. At the end of every group of N intervals it compares the latest estimate with a band that extends one tolerance either side of the bound. Above the band it raises the share by a programmable step. Below the band it lowers the share by that step. Inside the band it leaves the share alone. The share never goes beyond programmable lower and upper limits.

A separate monitor counts consecutive intervals whose slowdown is above the bound. When that run reaches N intervals it emits a one-cycle alert so that software can move or deschedule work. The alert fires again only after some interval has met the bound.

Top module: `qos_bw_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, `crit_share` equals `cfg_init_share`, `other_share` equals 256 minus that value, and `alert` is 0. Reset also clears the interval and miss counters.
- R2: Each cycle with `est_valid` high counts as one interval. The share is evaluated only on the interval that completes a group of `cfg_period` intervals (the 2nd, 4th, and so on when the period is 2). The intervals in between leave `crit_share` unchanged.
- R3: At an evaluation where `est_slowdown` > `cfg_bound` + `cfg_tol`, `crit_share` becomes min(share + `cfg_step`, `cfg_max`).
- R4: At an evaluation where `est_slowdown` + `cfg_tol` < `cfg_bound`, `crit_share` becomes max(share − `cfg_step`, `cfg_min`).
- R5: At an evaluation where `est_slowdown` lies in [bound − tol, bound + tol], both ends included, `crit_share` is unchanged.
- R6: `other_share` always equals 256 − `crit_share`. It is 9 bits wide so that the value 256 can be represented.
- R7: `alert` is a one-cycle pulse that appears in the cycle after the interval that makes `cfg_period` consecutive intervals with `est_slowdown` > `cfg_bound`. An interval with `est_slowdown` ≤ `cfg_bound` clears the run count. No further alert is issued until that has happened.
- R8: `crit_share` changes only in the cycle right after a cycle with `est_valid` high. It is updated one clock after the evaluating interval.
- R9: A `cfg_period` of 0 behaves like 1. Every interval is then evaluated, and a single interval above the bound raises the alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_init_share | input | 8 | Share loaded at reset (fraction of 256) |
| cfg_step | input | 8 | Adjustment step |
| cfg_min | input | 8 | Lower share limit |
| cfg_max | input | 8 | Upper share limit |
| cfg_bound | input | 16 | Slowdown bound, 8 fractional bits |
| cfg_tol | input | 16 | Tolerance, 8 fractional bits |
| cfg_period | input | 8 | Intervals per decision (N); 0 treated as 1 |
| est_valid | input | 1 | One slowdown estimate (one interval) this cycle |
| est_slowdown | input | 16 | Slowdown estimate, 8 fractional bits |
| crit_share | output | 8 | Share granted to the critical application |
| other_share | output | 9 | Share left for the other applications |
| alert | output | 1 | Sustained-miss pulse |

## Verification
The bench places estimates exactly on both band edges (bound + tol and bound − tol). A comparator that used the wrong inclusive or exclusive edge would move the share at those points when it should hold it. It places estimates between evaluation points to catch a controller that acts on every interval or counts the period one off. It drives the share into both limits with steps that would overshoot them, which exposes a sum that wraps or a limit that is ignored. It holds the slowdown above the bound for long runs: a monitor that fails to re-arm would pulse repeatedly, and one that never counts would stay silent. A period of 0 checks that the block does not stall or wait 256 intervals.

// File: rtl/qbw_pkg.sv
package qbw_pkg;

    localparam int SHARE_W = 8;

    typedef logic [SHARE_W-1:0] share_t;

    typedef enum logic [1:0] {
        DEC_HOLD = 2'd0,
        DEC_UP   = 2'd1,
        DEC_DOWN = 2'd2
    } decision_e;

    function automatic share_t share_raise(input share_t cur, input share_t step,
                                           input share_t hi);
        logic [SHARE_W:0] sum;
        sum = {1'b0, cur} + {1'b0, step};
        if (sum > {1'b0, hi}) return hi;
        return sum[SHARE_W-1:0];
    endfunction

    function automatic share_t share_lower(input share_t cur, input share_t step,
                                           input share_t lo);
        logic [SHARE_W:0] floor_plus;
        floor_plus = {1'b0, lo} + {1'b0, step};
        if ({1'b0, cur} < floor_plus) return lo;
        return cur - step;
    endfunction

endpackage

// File: rtl/qbw_band_cmp.sv
module qbw_band_cmp
    import qbw_pkg::*;
#(
    parameter int FP_W = 16
) (
    input  logic [FP_W-1:0] slow,
    input  logic [FP_W-1:0] bound,
    input  logic [FP_W-1:0] tol,
    output decision_e       dec,
    output logic            miss
);
    localparam int EXT_W = FP_W + 1;

    logic [EXT_W-1:0] upper_edge;
    logic [EXT_W-1:0] slow_plus_tol;

    always_comb begin
        upper_edge    = {1'b0, bound} + {1'b0, tol};
        slow_plus_tol = {1'b0, slow} + {1'b0, tol};
        if ({1'b0, slow} > upper_edge)
            dec = DEC_UP;
        else if (slow_plus_tol < {1'b0, bound})
            dec = DEC_DOWN;
        else
            dec = DEC_HOLD;
        miss = (slow > bound);
    end
endmodule

// File: rtl/qbw_period_ctr.sv
module qbw_period_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             eval
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = (limit == '0) ? '0 : limit - 1'b1;
        eval = tick && (cnt_q >= last);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= eval ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/qbw_share_reg.sv
module qbw_share_reg
    import qbw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  share_t    init,
    input  share_t    step,
    input  share_t    lo,
    input  share_t    hi,
    input  logic      apply,
    input  decision_e dec,
    output share_t    share
);
    share_t share_q;
    share_t share_d;

    always_comb begin
        share_d = share_q;
        if (apply) begin
            unique case (dec)
                DEC_UP:   share_d = share_raise(share_q, step, hi);
                DEC_DOWN: share_d = share_lower(share_q, step, lo);
                default:  share_d = share_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) share_q <= init;
        else     share_q <= share_d;
    end

    assign share = share_q;
endmodule

// File: rtl/qbw_miss_mon.sv
module qbw_miss_mon #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             miss,
    input  logic [CNT_W-1:0] limit,
    output logic             alert
);
    logic [CNT_W-1:0] run_q;
    logic             fired_q;
    logic             alert_q;
    logic [CNT_W-1:0] last;
    logic             hit;

    always_comb begin
        last = (limit == '0) ? '0 : limit - 1'b1;
        hit  = tick && miss && !fired_q && (run_q >= last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            fired_q <= 1'b0;
            alert_q <= 1'b0;
        end else begin
            alert_q <= hit;
            if (tick) begin
                if (!miss) begin
                    run_q   <= '0;
                    fired_q <= 1'b0;
                end else begin
                    if (run_q != '1) run_q <= run_q + 1'b1;
                    if (hit) fired_q <= 1'b1;
                end
            end
        end
    end

    assign alert = alert_q;
endmodule

// File: rtl/qos_bw_ctrl.sv
module qos_bw_ctrl
    import qbw_pkg::*;
#(
    parameter int FP_W  = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       cfg_init_share,
    input  logic [7:0]       cfg_step,
    input  logic [7:0]       cfg_min,
    input  logic [7:0]       cfg_max,
    input  logic [FP_W-1:0]  cfg_bound,
    input  logic [FP_W-1:0]  cfg_tol,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic             est_valid,
    input  logic [FP_W-1:0]  est_slowdown,
    output logic [7:0]       crit_share,
    output logic [8:0]       other_share,
    output logic             alert
);
    localparam int FULL = 1 << SHARE_W;

    decision_e dec;
    logic      miss;
    logic      eval;
    share_t    share;

    qbw_band_cmp #(.FP_W(FP_W)) u_cmp (
        .slow (est_slowdown),
        .bound(cfg_bound),
        .tol  (cfg_tol),
        .dec  (dec),
        .miss (miss)
    );

    qbw_period_ctr #(.CNT_W(CNT_W)) u_period (
        .clk  (clk),
        .rst  (rst),
        .tick (est_valid),
        .limit(cfg_period),
        .eval (eval)
    );

    qbw_share_reg u_share (
        .clk  (clk),
        .rst  (rst),
        .init (cfg_init_share),
        .step (cfg_step),
        .lo   (cfg_min),
        .hi   (cfg_max),
        .apply(eval),
        .dec  (dec),
        .share(share)
    );

    qbw_miss_mon #(.CNT_W(CNT_W)) u_miss (
        .clk  (clk),
        .rst  (rst),
        .tick (est_valid),
        .miss (miss),
        .limit(cfg_period),
        .alert(alert)
    );

    assign crit_share  = share;
    assign other_share = 9'(FULL) - {1'b0, share};
endmodule

// File: rtl/qbw_chk.sv
module qbw_chk #(
    parameter int FP_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [7:0]      cfg_max,
    input logic [7:0]      cfg_min,
    input logic [FP_W-1:0] cfg_bound,
    input logic [FP_W-1:0] cfg_tol,
    input logic            est_valid,
    input logic [FP_W-1:0] est_slowdown,
    input logic [7:0]      crit_share,
    input logic            alert
);
    logic [FP_W:0] up_edge;
    logic [FP_W:0] slow_tol;
    assign up_edge  = {1'b0, cfg_bound} + {1'b0, cfg_tol};
    assign slow_tol = {1'b0, est_slowdown} + {1'b0, cfg_tol};

    // R8
    share_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !est_valid |=> $stable(crit_share));

    // R3
    raise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && crit_share > $past(crit_share)) |->
            ($past({1'b0, est_slowdown}) > $past(up_edge)));

    // R3
    raise_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && crit_share > $past(crit_share)) |-> crit_share <= $past(cfg_max));

    // R4
    lower_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && crit_share < $past(crit_share)) |->
            ($past(slow_tol) < $past({1'b0, cfg_bound})));

    // R4
    lower_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && crit_share < $past(crit_share)) |-> crit_share >= $past(cfg_min));

    // R7
    alert_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        alert |=> !alert);

    // R7
    alert_cause_chk: assert property (@(posedge clk) disable iff (rst)
        alert |-> (!$past(rst) && $past(est_valid) && $past(est_slowdown) > $past(cfg_bound)));
endmodule

bind qos_bw_ctrl qbw_chk #(.FP_W(FP_W)) u_qbw_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_max     (cfg_max),
    .cfg_min     (cfg_min),
    .cfg_bound   (cfg_bound),
    .cfg_tol     (cfg_tol),
    .est_valid   (est_valid),
    .est_slowdown(est_slowdown),
    .crit_share  (crit_share),
    .alert       (alert)
);

// File: tb/test_qos_bw_ctrl.sv
module test_qos_bw_ctrl;
    localparam int PERIOD = 10;

    typedef struct packed {
        logic [15:0] slow;
        logic [7:0]  share;
        logic        alrt;
    } vec_t;

    // period 2, step 16, limits 32..224, bound 2.0, tol 0.25, start 128
    localparam vec_t VEC [12] = '{
        '{16'h0300, 8'd128, 1'b0},  // R2 no eval yet
        '{16'h0300, 8'd144, 1'b1},  // R3 up, R7 second miss
        '{16'h0300, 8'd144, 1'b0},  // R7 no refire
        '{16'h0300, 8'd160, 1'b0},  // R3
        '{16'h0200, 8'd160, 1'b0},  // meets bound, clears run
        '{16'h0240, 8'd160, 1'b0},  // R5 upper edge holds
        '{16'h01C0, 8'd160, 1'b0},
        '{16'h01C0, 8'd160, 1'b0},  // R5 lower edge holds
        '{16'h0100, 8'd160, 1'b0},
        '{16'h0100, 8'd144, 1'b0},  // R4 down
        '{16'h0241, 8'd144, 1'b0},
        '{16'h0241, 8'd160, 1'b1}   // R3, R7 re-armed
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_init_share = 8'd128;
    logic [7:0]  cfg_step = 8'd16;
    logic [7:0]  cfg_min = 8'd32;
    logic [7:0]  cfg_max = 8'd224;
    logic [15:0] cfg_bound = 16'h0200;
    logic [15:0] cfg_tol = 16'h0040;
    logic [7:0]  cfg_period = 8'd2;
    logic        est_valid = 1'b0;
    logic [15:0] est_slowdown = '0;
    logic [7:0]  crit_share;
    logic [8:0]  other_share;
    logic        alert;

    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    qos_bw_ctrl i_qos_bw_ctrl (
        .clk(clk), .rst(rst),
        .cfg_init_share(cfg_init_share), .cfg_step(cfg_step),
        .cfg_min(cfg_min), .cfg_max(cfg_max),
        .cfg_bound(cfg_bound), .cfg_tol(cfg_tol), .cfg_period(cfg_period),
        .est_valid(est_valid), .est_slowdown(est_slowdown),
        .crit_share(crit_share), .other_share(other_share), .alert(alert)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input int share, input int alrt);
        check({req, " share"}, int'(crit_share), share);
        check("R6 other", int'(other_share), 256 - share);
        check({req, " alert"}, int'(alert), alrt);
    endtask

    task automatic interval(input logic [15:0] s);
        @(negedge clk);
        est_valid    = 1'b1;
        est_slowdown = s;
        @(negedge clk);
        est_valid    = 1'b0;
    endtask

    task automatic do_reset(input logic [7:0] init);
        @(negedge clk);
        rst = 1'b1;
        cfg_init_share = init;
        repeat (3) @(negedge clk);
        check_state("R1 in reset", int'(init), 0);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1 after reset", int'(init), 0);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset(8'd128);

        foreach (VEC[i]) begin
            interval(VEC[i].slow);
            check_state("R2/R3/R4/R5/R7 table", int'(VEC[i].share), int'(VEC[i].alrt));
        end

        // R8: idle cycles leave share unchanged
        repeat (5) @(negedge clk);
        check_state("R8 idle", 160, 0);

        // R3 saturation at max, R7 no refire during long miss run
        for (int k = 0; k < 10; k++) begin
            interval(16'h0400);
            check("R7 no refire", int'(alert), 0);
        end
        check_state("R3 max clamp", 224, 0);

        // R4 saturation at min
        cfg_step = 8'd100;
        interval(16'h0080);
        interval(16'h0080);
        check_state("R4 down", 124, 0);
        interval(16'h0080);
        interval(16'h0080);
        check_state("R4 min clamp", 32, 0);
        interval(16'h0080);
        interval(16'h0080);
        check_state("R4 stays min", 32, 0);

        // R1 new init value
        cfg_step = 8'd16;
        cfg_period = 8'd0;
        do_reset(8'd77);

        // R9 period 0 acts as 1
        interval(16'h0400);
        check_state("R9 first", 93, 1);
        interval(16'h0400);
        check_state("R9 second", 109, 0);
        interval(16'h0100);
        check_state("R9 down", 93, 0);
        interval(16'h0400);
        check_state("R9 rearm", 109, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule